// File: doc/BRIEF.md
# Masked PCI Interrupt Summary Controller

This block gathers nineteen level-sensitive interrupt request lines and presents them to a processor through three consecutive byte-wide I/O ports on a simple ISA-style register bus. The lines are the four pins (A to D) of each of four PCI slots, plus the PCI-to-ISA bridge cascade, the IDE controller and the USB controller. Every request line passes through a two-flop synchronizer. Each line has its own mask bit. A mask bit of 1 blocks its line.

The mask can only be written. A read of a port always returns the live, synchronized request lines. It never returns the masked state or the mask itself. The block drives one combined interrupt output to the CPU. It also reports the index of the lowest-numbered pending unmasked line, together with a valid flag, so that service routines can take sources in ascending order. Index 4 is the bridge cascade, which hands off to the secondary ISA controller.

Software normally writes 0xFF to all three ports at start-up. It then clears individual mask bits to enable sources.

Top module: `pci_irq_summary`

## Requirements
- R1: After reset every mask bit is 1. With all request lines active, `cpu_irq` and `pend_valid` stay 0 and `pend_idx` is 0 until software clears a mask bit.
- R2: Source i counts as pending when its synchronized request is 1 and its mask bit is 0. A mask bit of 1 disables the source. `cpu_irq` is 1 exactly when at least one source is pending.
- R3: A write strobe at address 0x804+k (k = 0, 1, 2) loads the mask bits 8k to 8k+7 from all eight write-data bits in one cycle. The new mask takes effect right after that clock edge.
- R4: Source i sits at bit (i mod 8) of port 0x804+(i div 8), and `irq_req[i]` feeds source i. The mapping is as follows:
  - Port 0x804, bits 0 to 3: slot 0 to 3 pin A. Bit 4: bridge cascade. Bit 5: IDE. Bit 6: USB. Bit 7: slot 0 pin B.
  - Port 0x805, bits 0 to 2: slot 1 to 3 pin B. Bits 3 to 6: slot 0 to 3 pin C. Bit 7: slot 0 pin D.
  - Port 0x806, bits 0 to 2: slot 1 to 3 pin D.
  
  A read with `bus_rd` high returns the synchronized request lines of that port, whatever the mask holds.
- R5: Bits 3 to 7 of port 0x806 are reserved. They read as 0, and writing them has no effect on any source.
- R6: `bus_rdata` is 0 whenever `bus_rd` is low or the address lies outside 0x804 to 0x806. A write outside that range leaves the mask unchanged.
- R7: When a source is pending, `pend_valid` is 1 and `pend_idx` gives the lowest pending index. When no source is pending, both outputs are 0.
- R8: A change on a request line appears on reads, `cpu_irq` and `pend_idx` after the second rising clock edge that follows it, and not after the first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | 19 | Level-sensitive request lines, bit i = source i |
| bus_addr | input | 16 | I/O address |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_rdata | output | 8 | Read data, 0 when not selected |
| cpu_irq | output | 1 | Combined interrupt to the CPU |
| pend_idx | output | 5 | Lowest pending unmasked source index |
| pend_valid | output | 1 | A pending unmasked source exists |

## Verification
The hardest case to set up is one where the raw line state, the mask and the priority answer all disagree with one another. That means a read that shows lines which the mask hides, while the encoder points at a higher index because the lower lines are masked. The stimulus creates this by holding many request lines active and unmasking single high bits, one port at a time. It then checks that reads still show every line and that the reported index moves between ports as masks are loaded and reloaded. The two-edge synchronizer delay is checked by sampling one cycle early and again at the expected cycle.

// File: rtl/irqsum_pkg.sv
package irqsum_pkg;
    parameter int SRC_CNT_DEF  = 19;
    parameter int ADDR_W_DEF   = 16;
    parameter int BYTE_W       = 8;
    parameter logic [15:0] BASE_DEF = 16'h0804;

    function automatic int port_count(input int src_cnt);
        return (src_cnt + BYTE_W - 1) / BYTE_W;
    endfunction
endpackage

// File: rtl/irqsum_sync.sv
module irqsum_sync #(
    parameter int W = 19
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    typedef struct packed {
        logic [W-1:0] stage1;
        logic [W-1:0] stage2;
    } sync_state_t;

    sync_state_t state_d, state_q;

    always_comb begin
        state_d        = state_q;
        state_d.stage1 = async_in;
        state_d.stage2 = state_q.stage1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign sync_out = state_q.stage2;
endmodule

// File: rtl/irqsum_mask.sv
module irqsum_mask #(
    parameter int          W      = 19,
    parameter int          PORTS  = 3,
    parameter int          AW     = 16,
    parameter logic [AW-1:0] BASE = 16'h0804
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [W-1:0]  mask_q
);
    typedef struct packed {
        logic [W-1:0] mask;
    } mask_state_t;

    mask_state_t  state_d, state_q;
    logic [PORTS-1:0] port_hit;

    for (genvar p = 0; p < PORTS; p++) begin : g_hit
        assign port_hit[p] = wr_en && (addr == AW'(BASE + AW'(p)));
    end

    always_comb begin
        state_d = state_q;
        for (int p = 0; p < PORTS; p++) begin
            if (port_hit[p]) begin
                for (int b = 0; b < 8; b++) begin
                    if (p * 8 + b < W) state_d.mask[p * 8 + b] = wdata[b];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '{mask: '1};
        else        state_q <= state_d;
    end

    assign mask_q = state_q.mask;
endmodule

// File: rtl/irqsum_prio.sv
module irqsum_prio #(
    parameter int W  = 19,
    parameter int IW = 5
) (
    input  logic [W-1:0]  pend_vec,
    output logic [IW-1:0] low_idx,
    output logic          low_valid
);
    always_comb begin
        low_idx   = '0;
        low_valid = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            if (pend_vec[i]) begin
                low_idx   = IW'(i);
                low_valid = 1'b1;
            end
        end
    end
endmodule

// File: rtl/pci_irq_summary.sv
module pci_irq_summary
    import irqsum_pkg::*;
#(
    parameter int            SRC_CNT = SRC_CNT_DEF,
    parameter int            ADDR_W  = ADDR_W_DEF,
    parameter logic [ADDR_W-1:0] BASE = BASE_DEF,
    localparam int           PORTS   = port_count(SRC_CNT),
    localparam int           IDX_W   = $clog2(SRC_CNT),
    localparam int           PAD_W   = PORTS * BYTE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SRC_CNT-1:0] irq_req,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [7:0]         bus_wdata,
    input  logic               bus_rd,
    input  logic               bus_wr,
    output logic [7:0]         bus_rdata,
    output logic               cpu_irq,
    output logic [IDX_W-1:0]   pend_idx,
    output logic               pend_valid
);
    logic [SRC_CNT-1:0] req_sync;
    logic [SRC_CNT-1:0] mask_q;
    logic [SRC_CNT-1:0] pend_vec;
    logic [PAD_W-1:0]   raw_padded;
    logic [PORTS-1:0]   rd_hit;

    irqsum_sync #(.W(SRC_CNT)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (irq_req),
        .sync_out (req_sync)
    );

    irqsum_mask #(.W(SRC_CNT), .PORTS(PORTS), .AW(ADDR_W), .BASE(BASE)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (bus_wr),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .mask_q (mask_q)
    );

    assign pend_vec = req_sync & ~mask_q;
    assign cpu_irq  = |pend_vec;

    irqsum_prio #(.W(SRC_CNT), .IW(IDX_W)) u_prio (
        .pend_vec  (pend_vec),
        .low_idx   (pend_idx),
        .low_valid (pend_valid)
    );

    assign raw_padded = PAD_W'(req_sync);

    for (genvar p = 0; p < PORTS; p++) begin : g_rd
        assign rd_hit[p] = bus_rd && (bus_addr == ADDR_W'(BASE + ADDR_W'(p)));
    end

    always_comb begin
        bus_rdata = '0;
        for (int p = 0; p < PORTS; p++) begin
            if (rd_hit[p]) bus_rdata = raw_padded[p * 8 +: 8];
        end
    end
endmodule

// File: rtl/irqsum_chk.sv
module irqsum_chk #(
    parameter int            W    = 19,
    parameter int            IW   = 5,
    parameter int            AW   = 16,
    parameter logic [AW-1:0] BASE = 16'h0804
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] bus_addr,
    input logic [7:0]    bus_wdata,
    input logic          bus_rd,
    input logic          bus_wr,
    input logic [7:0]    bus_rdata,
    input logic          cpu_irq,
    input logic [IW-1:0] pend_idx,
    input logic          pend_valid,
    input logic [W-1:0]  mask_q,
    input logic [W-1:0]  pend_vec
);
    logic in_range;
    assign in_range = (bus_addr >= BASE) && (bus_addr <= AW'(BASE + AW'(2)));

    // R2 / R7: combined output agrees with the encoder's valid flag
    a_r2_irq_eq_valid: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq == pend_valid);

    // R3: a write to the first port loads its whole byte
    a_r3_byte_load: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == BASE) |=> mask_q[7:0] == $past(bus_wdata));

    // R6: out-of-range writes keep the mask
    a_r6_outside_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !in_range) |=> $stable(mask_q));

    // R6: read data is zero when not selected
    a_r6_rdata_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && in_range) |-> bus_rdata == 8'h00);

    // R7: reported index is pending and nothing lower is
    a_r7_lowest: assert property (@(posedge clk) disable iff (!rst_n)
        pend_valid |-> (pend_vec[pend_idx] &&
                        ((pend_vec & ((W'(1) << pend_idx) - W'(1))) == '0)));

    // R7: index is zero when nothing is pending
    a_r7_idle_idx: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_valid |-> pend_idx == '0);
endmodule

bind pci_irq_summary irqsum_chk #(
    .W(SRC_CNT), .IW(IDX_W), .AW(ADDR_W), .BASE(BASE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rd     (bus_rd),
    .bus_wr     (bus_wr),
    .bus_rdata  (bus_rdata),
    .cpu_irq    (cpu_irq),
    .pend_idx   (pend_idx),
    .pend_valid (pend_valid),
    .mask_q     (mask_q),
    .pend_vec   (pend_vec)
);

// File: tb/sim_pci_irq_summary.sv
`timescale 1ns/1ps
module sim_pci_irq_summary;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [18:0] irq_req = '0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_rdata;
    logic        cpu_irq;
    logic [4:0]  pend_idx;
    logic        pend_valid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pci_irq_summary u0 (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_rdata(bus_rdata), .cpu_irq(cpu_irq), .pend_idx(pend_idx),
        .pend_valid(pend_valid)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic set_req(input logic [18:0] v);
        @(negedge clk);
        irq_req = v;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic chk_out(input string tag, input logic irq, input logic [4:0] idx);
        chk({tag, " cpu_irq"}, 32'(cpu_irq), 32'(irq));
        chk({tag, " pend_valid"}, 32'(pend_valid), 32'(irq));
        chk({tag, " pend_idx"}, 32'(pend_idx), 32'(idx));
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk_out("R1 reset", 1'b0, 5'd0);
        set_req(19'h7FFFF);
        chk_out("R1 all lines masked", 1'b0, 5'd0);
        rd(16'h0804, d); chk("R4 port0 raw", 32'(d), 32'hFF);
        rd(16'h0805, d); chk("R4 port1 raw", 32'(d), 32'hFF);
        rd(16'h0806, d); chk("R5 port2 reserved zero", 32'(d), 32'h07);
    endtask

    task automatic t_mask();
        logic [7:0] d;
        wr(16'h0804, 8'hEF);
        chk_out("R2 bridge only", 1'b1, 5'd4);
        rd(16'h0804, d); chk("R4 read ignores mask", 32'(d), 32'hFF);
        wr(16'h0804, 8'hFF);
        wr(16'h0805, 8'h7F);
        chk_out("R3 port1 bit7", 1'b1, 5'd15);
        wr(16'h0806, 8'hFB);
        chk_out("R7 lower wins", 1'b1, 5'd15);
        wr(16'h0805, 8'hFF);
        chk_out("R3 port1 reload", 1'b1, 5'd18);
    endtask

    task automatic t_outside();
        logic [7:0] d;
        wr(16'h0803, 8'h00);
        wr(16'h0807, 8'h00);
        chk_out("R6 outside write", 1'b1, 5'd18);
        rd(16'h0807, d); chk("R6 outside read", 32'(d), 32'h00);
        rd(16'h0803, d); chk("R6 below read", 32'(d), 32'h00);
        @(negedge clk);
        bus_addr = 16'h0804; #1;
        chk("R6 no strobe", 32'(bus_rdata), 32'h00);
    endtask

    task automatic t_reserved();
        wr(16'h0804, 8'hFF);
        wr(16'h0805, 8'hFF);
        wr(16'h0806, 8'hF8);
        set_req(19'h70000);
        chk_out("R5 reserved ones ignored", 1'b1, 5'd16);
        wr(16'h0806, 8'h01);
        chk_out("R3 port2 bit0 masked", 1'b1, 5'd17);
        wr(16'h0806, 8'h07);
        chk_out("R2 all masked again", 1'b0, 5'd0);
    endtask

    task automatic t_prio();
        wr(16'h0804, 8'h00);
        wr(16'h0805, 8'h00);
        wr(16'h0806, 8'h00);
        set_req(19'h40000); chk_out("R7 top source", 1'b1, 5'd18);
        set_req(19'h00120); chk_out("R7 two sources", 1'b1, 5'd5);
        set_req(19'h00001); chk_out("R7 source zero", 1'b1, 5'd0);
        set_req(19'h00000); chk_out("R7 none", 1'b0, 5'd0);
    endtask

    task automatic t_layout();
        logic [7:0] d;
        set_req(19'h5A3C1);
        rd(16'h0804, d); chk("R4 layout port0", 32'(d), 32'hC1);
        rd(16'h0805, d); chk("R4 layout port1", 32'(d), 32'hA3);
        rd(16'h0806, d); chk("R4 layout port2", 32'(d), 32'h05);
        chk_out("R7 layout", 1'b1, 5'd0);
        set_req(19'h00000);
    endtask

    task automatic t_latency();
        logic [7:0] d;
        @(negedge clk);
        irq_req = 19'h00080;
        @(negedge clk);
        chk_out("R8 one edge", 1'b0, 5'd0);
        @(negedge clk);
        chk_out("R8 two edges", 1'b1, 5'd7);
        rd(16'h0804, d); chk("R8 read after sync", 32'(d), 32'h80);
        @(negedge clk);
        irq_req = 19'h00000;
        @(negedge clk);
        chk_out("R8 release one edge", 1'b1, 5'd7);
        @(negedge clk);
        chk_out("R8 release two edges", 1'b0, 5'd0);
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mask();
        t_outside();
        t_reserved();
        t_prio();
        t_layout();
        t_latency();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule